// File: doc/BRIEF.md
# Pushbutton debounce and single-pulse conditioner

This block turns a bouncing mechanical pushbutton into two clean signals for synchronous logic. The first stage runs on a slow sampling clock of about 100 Hz. It keeps a short history of button samples and changes its held output only when every sample in that history agrees. The held output is active low: it drops when a press is accepted, stays low while the button is held, and rises again only after the release is accepted.

The second stage runs on the system clock, which also drives the state machine that consumes the press. It carries the held level into that domain through a two-flop synchronizer. It then emits a pulse exactly one system clock wide on each accepted press, however long the button stays down. A release produces no pulse.

Top module: `pb_conditioner`

## Requirements
- R1: While `rst_n` is low, `db_n` is high (released) and `press_pulse` is low.
- R2: `db_n` goes low at the rising `sample_clk` edge that captures the fourth consecutive pressed sample (`button_raw` = 1 means pressed).
- R3: `db_n` goes high at the rising `sample_clk` edge that captures the fourth consecutive released sample (`button_raw` = 0).
- R4: If the last four samples are mixed, `db_n` keeps its value.
- R5: Each accepted press gives `press_pulse` high for exactly one `clk` cycle, however long the button is held.
- R6: After `db_n` falls, `press_pulse` is high in the `clk` cycle that begins at the second rising `clk` edge, and it is low in the cycles before and after.
- R7: An accepted release, where `db_n` rises, produces no pulse. `press_pulse` is only ever high while `db_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, shared with the consuming state machine |
| rst_n | input | 1 | Asynchronous active-low reset for both stages |
| sample_clk | input | 1 | Slow sampling clock, about 100 Hz |
| button_raw | input | 1 | Raw pushbutton level, 1 = pressed |
| db_n | output | 1 | Debounced level, low while a press is held |
| press_pulse | output | 1 | One-`clk`-wide pulse per accepted press |

## Verification
`db_n` is due at the same `sample_clk` edge that captures the deciding sample. The bench raises `sample_clk` on a falling `clk` edge and reads `db_n` 1 ns later, before the next rising `clk` edge. `press_pulse` is due two rising `clk` edges after `db_n` falls. The bench therefore reads it at the first, second and third falling `clk` edges after that point and expects 0, 1 and 0. A bit-level model of the four-sample history, driven through every 8-bit sample pattern, supplies the expected `db_n` after each sample and the expected total number of pulses.

// File: rtl/pb_conditioner.sv
module pb_conditioner #(
  parameter int SAMPLES     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_clk,
  input  logic button_raw,
  output logic db_n,
  output logic press_pulse
);

  logic [SAMPLES-1:0]     hist;
  logic [SAMPLES-1:0]     hist_nxt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  assign hist_nxt = {hist[SAMPLES-2:0], button_raw};

  always_ff @(posedge sample_clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      db_n <= 1'b1;
    end else begin
      hist <= hist_nxt;
      if (&hist_nxt)       db_n <= 1'b0;
      else if (~|hist_nxt) db_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], db_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign press_pulse = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

module pb_conditioner_chk #(
  parameter int SAMPLES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_clk,
  input logic [SAMPLES-1:0] hist,
  input logic               db_n,
  input logic               press_pulse
);

  // R2
  press_accept_chk: assert property (@(posedge sample_clk) disable iff (!rst_n)
    $fell(db_n) |-> (&hist));

  // R3
  release_accept_chk: assert property (@(posedge sample_clk) disable iff (!rst_n)
    $rose(db_n) |-> (~|hist));

  // R5
  single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);

  // R7
  pulse_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |-> !db_n);

endmodule

bind pb_conditioner pb_conditioner_chk #(.SAMPLES(SAMPLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_clk(sample_clk),
  .hist(hist), .db_n(db_n), .press_pulse(press_pulse)
);

// File: tb/sim_pb_conditioner.sv
`timescale 1ns/1ps
module sim_pb_conditioner;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sample_clk = 1'b0;
  logic button_raw = 1'b0;
  logic db_n, press_pulse;

  int checks = 0, failures = 0;
  int pulses = 0, exp_pulses = 0, run_len = 0;
  bit done = 1'b0;
  bit mdb = 1'b1;
  bit [3:0] mh = 4'h0;

  pb_conditioner u0 (.clk(clk), .rst_n(rst_n), .sample_clk(sample_clk),
                     .button_raw(button_raw), .db_n(db_n), .press_pulse(press_pulse));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (press_pulse) begin
        run_len++;
        if (run_len == 1) pulses++;
      end else begin
        if (run_len != 0) check_int("R5 pulse width", run_len, 1);
        run_len = 0;
      end
    end
  end

  function automatic string model_step(input bit b);
    bit old = mdb;
    mh = {mh[2:0], b};
    if (mh == 4'hF) mdb = 1'b0;
    else if (mh == 4'h0) mdb = 1'b1;
    if (old && !mdb) exp_pulses++;
    if (old != mdb) return mdb ? "R3" : "R2";
    return "R4";
  endfunction

  task automatic tick(input bit b);
    string tag;
    @(negedge clk);
    button_raw = b;
    sample_clk = 1'b1;
    tag = model_step(b);
    #1 check(tag, db_n, mdb);
    @(negedge clk);
    sample_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    string tag;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 db_n", db_n, 1'b1);
    check("R1 pulse", press_pulse, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: short bursts leave the level alone
    tick(1); tick(1); tick(0); tick(1); tick(1); tick(1); tick(0);
    check_int("R4 no pulse", pulses, 0);

    // R6: latency of the pulse after the fourth pressed sample
    tick(1); tick(1); tick(1);
    @(negedge clk);
    button_raw = 1'b1;
    sample_clk = 1'b1;
    tag = model_step(1'b1);
    #1 check("R2 fall", db_n, 1'b0);
    @(negedge clk);
    sample_clk = 1'b0;
    check("R6 cycle 1", press_pulse, 1'b0);
    @(negedge clk);
    check("R6 cycle 2", press_pulse, 1'b1);
    @(negedge clk);
    check("R6 cycle 3", press_pulse, 1'b0);
    repeat (3) @(negedge clk);

    // R5: long hold gives one pulse
    repeat (20) tick(1);
    check_int("R5 hold", pulses, 1);

    // R7: release makes no pulse
    repeat (4) tick(0);
    check("R3 released", db_n, 1'b1);
    repeat (4) @(negedge clk);
    check_int("R7 release", pulses, 1);

    // sweep every 8-bit sample pattern
    for (int p = 0; p < 256; p++)
      for (int i = 7; i >= 0; i--) tick(p[i]);
    repeat (6) @(negedge clk);
    check_int("R5 total pulses", pulses, exp_pulses);

    finish_run();
  end
endmodule